// File: doc/BRIEF.md
# NAND Flash Boot Page Copier

This block is a hardware sequencer that moves a boot image from a raw NAND flash with a 16-bit data bus into on-chip RAM. It works one page at a time. For every page it issues a fresh read command and a fresh set of addresses. It does not stream through the device in one linear pass, because that pass would run on into the spare area. Once the flash reports ready, the block reads the page's words and writes each one to a RAM write port.

A one-cycle `start` pulse launches a copy. The pulse is qualified by `boot_nand`, which says whether NAND boot mode is selected. The caller supplies a destination byte address, a source byte offset and a signed byte count. The block halves the source offset to get the word offset that the 16-bit device expects. When the copy is over it releases chip enable and pulses `done`. If NAND boot is not selected, it reports `done` without ever touching the flash.

Top module: `nand_page_loader`

## Requirements
- R1: When `start` arrives with `boot_nand` low, `done` is high in the cycle after the start edge, for that one cycle only. No flash line leaves its idle level (idle means `flash_ce_n`=1, `flash_we_n`=1, `flash_re_n`=1, `flash_cle`=0, `flash_ale`=0), and `ram_we` never rises.
- R2: The word offset is the source byte offset shifted right by one. It grows by PAGE_WORDS for each page. The first row address byte is bits [15:8] of the word offset and the second is bits [23:16]; each is sent on `flash_dout[7:0]` with `flash_dout[15:8]`=0.
- R3: Each page begins with chip enable low and command latch high, and the read command value 0x0000 is strobed on `flash_dout`.
- R4: Command latch stays high for SETTLE+2 cycles per page: the strobe, one recovery cycle and SETTLE settle cycles. Address latch stays high for SETTLE+6 cycles per page. The two latch lines are never high together.
- R5: The address phase strobes three values with address latch high, in this order: column 0x0000, row byte 0, row byte 1.
- R6: `flash_re_n` never falls while `flash_rb` is low. Reading starts only after ready/busy is seen high.
- R7: Every word read is written to RAM with a single-cycle `ram_we`. Word k of the copy goes to byte address `dst_addr`+2k.
- R8: The number of pages is 1 when `size_bytes` is negative. Otherwise it is floor(`size_bytes`/(2·PAGE_WORDS))+1. Each page reads exactly PAGE_WORDS words.
- R9: Each read holds `flash_re_n` low for RD_WAIT+1 cycles. The word written to RAM is the `flash_din` value present during that low period.
- R10: At the end of a copy, `done` pulses for exactly one cycle with `flash_ce_n` high.
- R11: A `start` that arrives while a copy is running is ignored.
- R12: Every write strobe on `flash_we_n` is low for exactly one cycle, with at least one high cycle before the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Copy request pulse |
| boot_nand | input | 1 | High when NAND boot mode is selected |
| dst_addr | input | AW | RAM destination byte address |
| src_off | input | OW | Flash source byte offset |
| size_bytes | input | SW | Signed byte count |
| flash_rb | input | 1 | Flash ready (high) / busy (low) |
| flash_din | input | 16 | Flash read data |
| done | output | 1 | One-cycle completion pulse |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_cle | output | 1 | Command latch enable |
| flash_ale | output | 1 | Address latch enable |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_re_n | output | 1 | Read strobe, active low |
| flash_dout | output | 16 | Command and address value driven to the flash |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | AW | RAM byte address |
| ram_wdata | output | 16 | RAM write data |

## Verification
The bench sweeps sizes on both sides of each page multiple, including negative and zero counts. A design that gets the page count wrong writes one page too many or one too few. It also uses source offsets whose word offset crosses a row-byte boundary partway through a copy. A design that forgets to halve the offset, or that never advances it, sends wrong row bytes there. A behavioural flash model holds ready/busy low well past the settle delay, so a design that reads too early is caught. A second start fired in the middle of a copy must leave the page count and the RAM contents untouched, and the skipped-flash path with NAND boot deselected must show no activity at all.

// File: rtl/nplc_pkg.sv
package nplc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_SET1, S_COL, S_ROW0, S_ROW1,
    S_SET2, S_RB, S_RDLO, S_RDHI, S_FIN
  } nplc_state_t;
endpackage

// File: rtl/nplc_countdown.sv
module nplc_countdown #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nplc_tracker.sv
module nplc_tracker #(
  parameter int AW         = 16,
  parameter int OW         = 32,
  parameter int SW         = 32,
  parameter int PAGE_WORDS = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic [OW-1:0] src_off,
  input  logic [SW-1:0] size_bytes,
  input  logic [AW-1:0] dst_addr,
  input  logic          word_adv,
  input  logic          page_adv,
  output logic [7:0]    row_lo,
  output logic [7:0]    row_hi,
  output logic [AW-1:0] ptr,
  output logic          page_end,
  output logic          more
);
  localparam int IW = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
  localparam logic [SW:0]   PSTEP = (SW+1)'(2 * PAGE_WORDS);
  localparam logic [OW-1:0] WSTEP = OW'(PAGE_WORDS);
  localparam logic [IW-1:0] WLAST = IW'(PAGE_WORDS - 1);

  logic [OW-1:0] woff;
  logic [SW-1:0] rem;
  logic [IW-1:0] widx;
  logic [SW:0]   rem_nxt;

  assign rem_nxt = {rem[SW-1], rem} - PSTEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      woff <= '0;
      rem  <= '0;
      ptr  <= '0;
      widx <= '0;
    end else if (init) begin
      woff <= {1'b0, src_off[OW-1:1]};
      rem  <= size_bytes;
      ptr  <= dst_addr;
      widx <= '0;
    end else begin
      if (word_adv) begin
        ptr  <= ptr + AW'(2);
        widx <= (widx == WLAST) ? '0 : widx + 1'b1;
      end
      if (page_adv) begin
        rem  <= rem_nxt[SW-1:0];
        woff <= woff + WSTEP;
      end
    end
  end

  assign row_lo   = woff[15:8];
  assign row_hi   = woff[23:16];
  assign page_end = (widx == '0);
  assign more     = ~rem_nxt[SW];
endmodule

// File: rtl/nand_page_loader.sv
module nand_page_loader
  import nplc_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          OW         = 32,
  parameter int          SW         = 32,
  parameter int          PAGE_WORDS = 256,
  parameter int          SETTLE     = 20,
  parameter int          RD_WAIT    = 2,
  parameter logic [7:0]  CMD_READ   = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          boot_nand,
  input  logic [AW-1:0] dst_addr,
  input  logic [OW-1:0] src_off,
  input  logic [SW-1:0] size_bytes,
  input  logic          flash_rb,
  input  logic [15:0]   flash_din,
  output logic          done,
  output logic          flash_ce_n,
  output logic          flash_cle,
  output logic          flash_ale,
  output logic          flash_we_n,
  output logic          flash_re_n,
  output logic [15:0]   flash_dout,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [15:0]   ram_wdata
);
  localparam int TMAX = (SETTLE > RD_WAIT) ? SETTLE : RD_WAIT;
  localparam int TW   = (TMAX > 1) ? $clog2(TMAX + 1) : 1;
  localparam logic [TW-1:0] T_SET = TW'(SETTLE - 1);
  localparam logic [TW-1:0] T_RD  = TW'(RD_WAIT);

  nplc_state_t st, st_d;
  logic        wph, wph_d;
  logic        tmr_ld, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic        trk_init, word_adv, page_adv, page_end, more;
  logic [7:0]  row_lo, row_hi;
  logic [AW-1:0] ptr;
  logic        is_wr;
  logic [15:0] dout_d;

  nplc_countdown #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_ld), .val(tmr_val), .zero(tmr_zero)
  );

  nplc_tracker #(.AW(AW), .OW(OW), .SW(SW), .PAGE_WORDS(PAGE_WORDS)) u_trk (
    .clk(clk), .rst(rst), .init(trk_init), .src_off(src_off),
    .size_bytes(size_bytes), .dst_addr(dst_addr), .word_adv(word_adv),
    .page_adv(page_adv), .row_lo(row_lo), .row_hi(row_hi), .ptr(ptr),
    .page_end(page_end), .more(more)
  );

  always_comb begin
    st_d     = st;
    wph_d    = wph;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    trk_init = 1'b0;
    word_adv = 1'b0;
    page_adv = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        if (boot_nand) begin
          st_d = S_CMD; wph_d = 1'b0; trk_init = 1'b1;
        end else begin
          st_d = S_FIN;
        end
      end
      S_CMD: if (!wph) wph_d = 1'b1;
             else begin st_d = S_SET1; wph_d = 1'b0; tmr_ld = 1'b1; tmr_val = T_SET; end
      S_SET1: if (tmr_zero) begin st_d = S_COL; wph_d = 1'b0; end
      S_COL: if (!wph) wph_d = 1'b1;
             else begin st_d = S_ROW0; wph_d = 1'b0; end
      S_ROW0: if (!wph) wph_d = 1'b1;
              else begin st_d = S_ROW1; wph_d = 1'b0; end
      S_ROW1: if (!wph) wph_d = 1'b1;
              else begin st_d = S_SET2; wph_d = 1'b0; tmr_ld = 1'b1; tmr_val = T_SET; end
      S_SET2: if (tmr_zero) st_d = S_RB;
      S_RB: if (flash_rb) begin st_d = S_RDLO; tmr_ld = 1'b1; tmr_val = T_RD; end
      S_RDLO: if (tmr_zero) begin st_d = S_RDHI; word_adv = 1'b1; end
      S_RDHI: if (!page_end) begin
                st_d = S_RDLO; tmr_ld = 1'b1; tmr_val = T_RD;
              end else begin
                page_adv = 1'b1;
                if (more) begin st_d = S_CMD; wph_d = 1'b0; end
                else st_d = S_FIN;
              end
      S_FIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign is_wr = (st_d == S_CMD) || (st_d == S_COL) ||
                 (st_d == S_ROW0) || (st_d == S_ROW1);

  always_comb begin
    case (st_d)
      S_CMD:   dout_d = {8'h00, CMD_READ};
      S_ROW0:  dout_d = {8'h00, row_lo};
      S_ROW1:  dout_d = {8'h00, row_hi};
      default: dout_d = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      wph        <= 1'b0;
      done       <= 1'b0;
      flash_ce_n <= 1'b1;
      flash_cle  <= 1'b0;
      flash_ale  <= 1'b0;
      flash_we_n <= 1'b1;
      flash_re_n <= 1'b1;
      flash_dout <= '0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
    end else begin
      st         <= st_d;
      wph        <= wph_d;
      done       <= (st_d == S_FIN);
      flash_ce_n <= (st_d == S_IDLE) || (st_d == S_FIN);
      flash_cle  <= (st_d == S_CMD) || (st_d == S_SET1);
      flash_ale  <= (st_d == S_COL) || (st_d == S_ROW0) ||
                    (st_d == S_ROW1) || (st_d == S_SET2);
      flash_we_n <= !(is_wr && !wph_d);
      flash_re_n <= (st_d != S_RDLO);
      flash_dout <= dout_d;
      ram_we     <= word_adv;
      if (word_adv) begin
        ram_addr  <= ptr;
        ram_wdata <= flash_din;
      end
    end
  end
endmodule

// File: rtl/nplc_chk.sv
module nplc_chk (
  input logic clk,
  input logic rst,
  input logic done,
  input logic flash_ce_n,
  input logic flash_cle,
  input logic flash_ale,
  input logic flash_we_n,
  input logic flash_re_n,
  input logic flash_rb,
  input logic ram_we
);
  p_ce_high_at_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> flash_ce_n);
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_latch_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(flash_cle && flash_ale));
  p_strobe_single_r12: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n |=> flash_we_n);
  p_we_under_ce_r3: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n |-> !flash_ce_n);
  p_read_when_ready_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(flash_re_n) |-> flash_rb);
  p_ram_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);
endmodule

bind nand_page_loader nplc_chk u_chk (
  .clk(clk), .rst(rst), .done(done), .flash_ce_n(flash_ce_n),
  .flash_cle(flash_cle), .flash_ale(flash_ale), .flash_we_n(flash_we_n),
  .flash_re_n(flash_re_n), .flash_rb(flash_rb), .ram_we(ram_we)
);

// File: tb/sim_nand_page_loader.sv
`timescale 1ns/1ps
module sim_nand_page_loader;
  localparam int AW = 16, OW = 32, SW = 32;
  localparam int PW = 16, SETTLE = 20, RDW = 1, BUSY = 30;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, boot_nand = 1'b0;
  logic [AW-1:0] dst_addr = '0;
  logic [OW-1:0] src_off = '0;
  logic [SW-1:0] size_bytes = '0;
  logic flash_rb = 1'b1;
  logic [15:0] flash_din = '0;
  logic done, flash_ce_n, flash_cle, flash_ale, flash_we_n, flash_re_n, ram_we;
  logic [15:0] flash_dout, ram_wdata;
  logic [AW-1:0] ram_addr;

  always #5 clk = ~clk;

  nand_page_loader #(.AW(AW), .OW(OW), .SW(SW), .PAGE_WORDS(PW),
                     .SETTLE(SETTLE), .RD_WAIT(RDW)) u0 (.*);

  int checks = 0, errors = 0;
  int cyc = 0;

  // flash model and bus monitor state
  int pg, aseq, busy, rdc, act, nwr, odd, bad_we, bad_re, rb_viol, lo_we, lo_re;
  logic pwe = 1'b1, pre = 1'b1, pcle = 1'b0;
  logic [15:0] cmdv [8];
  logic [15:0] colv [8];
  logic [15:0] r0v [8];
  logic [15:0] r1v [8];
  int cle_c [8];
  int ale_c [8];
  logic [15:0] mem [1024];

  function automatic logic [15:0] pat(int k);
    return 16'h5A3C ^ 16'(k * 263);
  endfunction

  task automatic chk(input bit ok, input string req, input longint a, input longint e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst && ram_we) begin
      nwr++;
      if (ram_addr[0]) odd++;
      mem[ram_addr[10:1]] = ram_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (!flash_ce_n) act++;
      if (flash_cle && !pcle) pg++;
      if (pg > 0 && pg <= 8) begin
        if (flash_cle) cle_c[pg-1]++;
        if (flash_ale) ale_c[pg-1]++;
      end
      if (!flash_we_n) lo_we++;
      if (flash_we_n && !pwe) begin
        if (lo_we != 1) bad_we++;
        lo_we = 0;
        if (pg > 0 && pg <= 8) begin
          if (flash_cle) begin cmdv[pg-1] = flash_dout; aseq = 0; end
          else if (flash_ale) begin
            if (aseq == 0) colv[pg-1] = flash_dout;
            else if (aseq == 1) r0v[pg-1] = flash_dout;
            else if (aseq == 2) begin r1v[pg-1] = flash_dout; busy = BUSY; end
            aseq++;
          end
        end
      end
      if (!flash_re_n) begin
        lo_re++;
        if (!flash_rb) rb_viol++;
      end
      if (flash_re_n && !pre) begin
        if (lo_re != RDW + 1) bad_re++;
        lo_re = 0;
        rdc++;
      end
      if (busy > 0) busy--;
      flash_rb = (busy == 0);
      flash_din = pat(rdc);
      pwe = flash_we_n; pre = flash_re_n; pcle = flash_cle;
    end
  end

  task automatic clear_model();
    pg = 0; aseq = 0; busy = 0; rdc = 0; act = 0; nwr = 0; odd = 0;
    bad_we = 0; bad_re = 0; rb_viol = 0; lo_we = 0; lo_re = 0;
    for (int i = 0; i < 8; i++) begin
      cle_c[i] = 0; ale_c[i] = 0; cmdv[i] = 16'hFFFF; colv[i] = 16'hFFFF;
      r0v[i] = 16'hFFFF; r1v[i] = 16'hFFFF;
    end
    for (int i = 0; i < 1024; i++) mem[i] = 16'hDEAD;
  endtask

  task automatic run(input logic [OW-1:0] so, input int sz, input logic [AW-1:0] dst,
                     input bit dbl);
    int pages, dseen, t, bad;
    logic [OW-1:0] w;
    clear_model();
    pages = (sz < 0) ? 1 : sz / (2 * PW) + 1;
    @(negedge clk);
    src_off = so; size_bytes = SW'(sz); dst_addr = dst; boot_nand = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dbl) begin
      repeat (60) @(negedge clk);
      dst_addr = dst + 16'h0200; size_bytes = 32'd200; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    dseen = 0; t = 0;
    while (dseen == 0 && t < 20000) begin
      if (done) begin
        dseen = 1;
        chk(flash_ce_n == 1'b1, "R10 ce_n at done", flash_ce_n, 1);
      end
      @(negedge clk); t++;
    end
    chk(dseen == 1, "R10 done seen", dseen, 1);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    repeat (30) @(negedge clk);
    chk(pg == pages, "R8 page count", pg, pages);
    chk(nwr == pages * PW && odd == 0, "R7 ram writes", nwr, pages * PW);
    if (dbl) chk(pg == pages && nwr == pages * PW, "R11 restart ignored", nwr, pages * PW);
    chk(bad_we == 0, "R12 strobe width", bad_we, 0);
    chk(bad_re == 0, "R9 read low width", bad_re, 0);
    chk(rb_viol == 0, "R6 read while busy", rb_viol, 0);
    for (int p = 0; p < pages && p < 8; p++) begin
      w = (so >> 1) + OW'(p * PW);
      chk(cmdv[p] == 16'h0000, "R3 read command", cmdv[p], 0);
      chk(colv[p] == 16'h0000, "R5 column zero", colv[p], 0);
      chk(r0v[p] == {8'h00, w[15:8]}, "R2 row byte 0", r0v[p], w[15:8]);
      chk(r1v[p] == {8'h00, w[23:16]}, "R2 row byte 1", r1v[p], w[23:16]);
      chk(cle_c[p] == SETTLE + 2, "R4 cle cycles", cle_c[p], SETTLE + 2);
      chk(ale_c[p] == SETTLE + 6, "R4 ale cycles", ale_c[p], SETTLE + 6);
    end
    bad = 0;
    for (int k = 0; k < pages * PW; k++)
      if (mem[(int'(dst) >> 1) + k] != pat(k)) bad++;
    chk(bad == 0, "R9 R7 data placement", bad, 0);
  endtask

  initial begin
    int szl [11] = '{-3, 0, 1, 31, 32, 33, 63, 64, 100, 127, 128};
    logic [OW-1:0] offl [3] = '{32'h0, 32'd480, 32'h001F_FFC0};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && flash_ce_n == 1 && flash_cle == 0 && flash_ale == 0 &&
        flash_we_n == 1 && flash_re_n == 1 && ram_we == 0, "R10 reset state", 0, 0);

    // R1: no NAND boot
    clear_model();
    boot_nand = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R1 immediate done", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R1 done single", done, 0);
    repeat (40) @(negedge clk);
    chk(act == 0 && pg == 0 && nwr == 0, "R1 flash untouched", act + nwr, 0);

    for (int o = 0; o < 3; o++)
      for (int s = 0; s < 11; s++)
        run(offl[o], szl[s], (s % 2) ? 16'h0100 : 16'h0040, 1'b0);

    run(32'd480, 64, 16'h0080, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule